// File: doc/BRIEF.md
# DRAM Idle Low-Power Escalation Controller

This block sits beside a memory controller and watches its bus-request line. While no request is present it counts consecutive idle DFI clock cycles (one DFI clock equals two DRAM clocks). Five programmable thresholds set how long the bus must stay idle before the memory is moved to each low-power level. The levels, from shallowest to deepest, are power-down, self-refresh, self-refresh with the controller clock gated, self-refresh power-down (LPDDR4 only), and standby. Standby keeps the memory in self-refresh and gates the controller, DFI, PHY and DRAM clocks.

Changes to the memory mode go through a simplified command port as a one-cycle strobe with an opcode. The block then waits for an acknowledge before it treats the new level as reached. A level that only changes clock gating takes effect without a command. A bus request that arrives in any low-power level releases all clock gates, issues an exit command and holds the bus off until the exit is acknowledged. The idle counter is then cleared and the controller is active again.

Power-down and standby thresholds count plain DFI cycles. The three self-refresh thresholds are multiplied by 2^SCALE_SH, which defaults to 1024.

Top module: `lp_idle_ctrl`

## Requirements
- R1: After reset the level is active (lp_state_o = 0), bus_rdy_o = 1, clk_en_o = 4'hF, no command strobe is issued and all thresholds are 0.
- R2: With power-down threshold N (register address 0, unscaled), the clock edge that samples the bus idle for the (N+1)-th consecutive time issues a command with opcode 1. The level becomes 1 on the edge that samples the acknowledge.
- R3: The self-refresh threshold (address 1) counts in units of 2^SCALE_SH idle cycles. On expiry it issues opcode 2, and after the acknowledge the level is 2.
- R4: The gated self-refresh threshold (address 2, scaled) moves the level to 3 and drives clk_en_o bit 0 (controller clock) low. When the memory is already in self-refresh, no command is issued.
- R5: The self-refresh power-down threshold (address 3, scaled, opcode 3, level 4) is honoured only when dram_type_i was 2 (LPDDR4) at the first clock edge after reset. Values 0 (DDR3) and 1 (LPDDR3) disable it.
- R6: Standby (address 4, unscaled, level 5) drives clk_en_o to 0. If the memory is not yet in self-refresh, opcode 2 is issued first, and the clocks are gated only after its acknowledge.
- R7: A threshold of 0 disables its level, so that level is never entered on idle.
- R8: When several thresholds have expired, the deepest enabled one is targeted. While idle persists, the level only ever moves deeper.
- R9: A bus request in a low-power level drives clk_en_o to 4'hF for one cycle. The next cycle carries an exit strobe with opcode 4. bus_rdy_o stays 0 until the exit acknowledge has been sampled, and the level then returns to 0.
- R10: After an exit the idle count restarts from zero, so entry timing again matches R2.
- R11: Threshold writes are accepted only while the level is 0 with no command outstanding. Writes at any other time, and writes to addresses 5 to 7, have no effect.
- R12: cmd_vld_o is a single-cycle strobe. Each memory-mode change produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DFI clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dram_type_i | input | 2 | Memory type, 0 DDR3, 1 LPDDR3, 2 LPDDR4, sampled once after reset |
| bus_req_i | input | 1 | Bus request / activity from the controller |
| bus_rdy_o | output | 1 | Requests may proceed (active level, nothing pending) |
| reg_we_i | input | 1 | Threshold write enable |
| reg_addr_i | input | 3 | Threshold select, 0 PD, 1 SR, 2 gated SR, 3 SR power-down, 4 standby |
| reg_wdata_i | input | THR_W | Threshold value |
| cmd_vld_o | output | 1 | Command strobe to the DRAM command port |
| cmd_op_o | output | 3 | Opcode, 1 PD entry, 2 SR entry, 3 SR power-down entry, 4 exit |
| cmd_ack_i | input | 1 | Command completion acknowledge |
| clk_en_o | output | 4 | Clock enables, bit 0 controller, 1 DFI, 2 PHY, 3 DRAM |
| lp_state_o | output | 3 | Current level, 0 active to 5 standby |

## Verification
The bench builds the controller with THR_W = 8 and SCALE_SH = 3, so one scaled threshold step is eight idle cycles instead of 1024. Every level, including standby reached from an ungated self-refresh and standby reached straight from active, is therefore entered within a few dozen cycles. With the small scale the bench can run two resets, one with a DDR3 type and one with an LPDDR4 type, and can raise a wake request while an entry acknowledge is still pending. Entry cycle counts can then be compared exactly against threshold plus one.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int NUM_LVL = 5;
  localparam int NUM_CLK = 4;

  typedef enum logic [2:0] {
    LV_ACT  = 3'd0,
    LV_PD   = 3'd1,
    LV_SR   = 3'd2,
    LV_SRG  = 3'd3,
    LV_SRPD = 3'd4,
    LV_STBY = 3'd5
  } lp_lvl_e;

  typedef enum logic [1:0] {
    PH_RUN,
    PH_ENTER,
    PH_UNGATE,
    PH_EXIT
  } lp_ph_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PD   = 3'd1,
    OP_SR   = 3'd2,
    OP_SRPD = 3'd3,
    OP_EXIT = 3'd4
  } lp_op_e;

  localparam logic [1:0] DT_LP4 = 2'd2;

  // memory-side mode a level implies
  function automatic lp_op_e lvl_mode(lp_lvl_e l);
    case (l)
      LV_PD:                    return OP_PD;
      LV_SR, LV_SRG, LV_STBY:   return OP_SR;
      LV_SRPD:                  return OP_SRPD;
      default:                  return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/lp_thr_regs.sv
module lp_thr_regs
  import lp_pkg::*;
#(
  parameter int THR_W    = 16,
  parameter int SCALE_SH = 10,
  parameter int ADDR_W   = 3,
  localparam int CNT_W   = THR_W + SCALE_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [THR_W-1:0]  wdata_i,
  input  logic              wr_ok_i,
  input  logic              lp4_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [NUM_LVL-1:0] expired_o
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    localparam bit SCALED   = (g >= 1) && (g <= 3);
    localparam bit LP4_ONLY = (g == 3);

    logic [THR_W-1:0] thr_q;
    logic [CNT_W-1:0] lim;
    logic             hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thr_q <= '0;
      else if (we_i && wr_ok_i && (addr_i == ADDR_W'(g))) thr_q <= wdata_i;
    end

    if (SCALED) begin : g_sc
      assign lim = {thr_q, {SCALE_SH{1'b0}}};
    end else begin : g_pl
      assign lim = {{SCALE_SH{1'b0}}, thr_q};
    end

    assign hit = (thr_q != '0) && (cnt_i >= lim);

    if (LP4_ONLY) begin : g_lp4
      assign expired_o[g] = hit && lp4_i;
    end else begin : g_any
      assign expired_o[g] = hit;
    end
  end
endmodule

// File: rtl/lp_idle_cnt.sv
module lp_idle_cnt #(
  parameter int CNT_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             hold_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (idle_i) begin
      if (cnt_q != '1)          cnt_q <= cnt_q + 1'b1;
    end else if (!hold_i)       cnt_q <= '0;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lp_seq.sv
module lp_seq
  import lp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_req_i,
  input  logic [NUM_LVL-1:0] expired_i,
  input  logic               ack_i,
  output lp_lvl_e            lvl_o,
  output lp_ph_e             ph_o,
  output logic               cmd_vld_o,
  output lp_op_e             cmd_op_o,
  output logic               clr_o
);
  lp_lvl_e lvl_q, pend_q, tgt;
  lp_ph_e  ph_q;
  logic    vld_q;
  lp_op_e  op_q;

  // deepest expired level
  always_comb begin
    tgt = LV_ACT;
    for (int k = 1; k <= NUM_LVL; k++) begin
      if (expired_i[k-1]) tgt = lp_lvl_e'(k[2:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LV_ACT;
      pend_q <= LV_ACT;
      ph_q   <= PH_RUN;
      vld_q  <= 1'b0;
      op_q   <= OP_NONE;
    end else begin
      vld_q <= 1'b0;
      case (ph_q)
        PH_RUN: begin
          if (lvl_q != LV_ACT && bus_req_i) begin
            ph_q <= PH_UNGATE;
          end else if (!bus_req_i && tgt > lvl_q) begin
            if (lvl_mode(tgt) != lvl_mode(lvl_q)) begin
              vld_q  <= 1'b1;
              op_q   <= lvl_mode(tgt);
              pend_q <= tgt;
              ph_q   <= PH_ENTER;
            end else begin
              lvl_q <= tgt;  // gating-only step
            end
          end
        end
        PH_ENTER: begin
          if (ack_i) begin
            lvl_q <= pend_q;
            ph_q  <= PH_RUN;
          end
        end
        PH_UNGATE: begin
          vld_q <= 1'b1;
          op_q  <= OP_EXIT;
          ph_q  <= PH_EXIT;
        end
        default: begin
          if (ack_i) begin
            lvl_q <= LV_ACT;
            ph_q  <= PH_RUN;
          end
        end
      endcase
    end
  end

  assign lvl_o     = lvl_q;
  assign ph_o      = ph_q;
  assign cmd_vld_o = vld_q;
  assign cmd_op_o  = op_q;
  assign clr_o     = (ph_q == PH_EXIT) && ack_i;
endmodule

// File: rtl/lp_gate_dec.sv
module lp_gate_dec
  import lp_pkg::*;
(
  input  lp_lvl_e            lvl_i,
  input  lp_ph_e             ph_i,
  output logic [NUM_CLK-1:0] en_o
);
  logic waking;
  assign waking = (ph_i == PH_UNGATE) || (ph_i == PH_EXIT);

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_clk
    // controller clock stops from gated SR on, the rest only in standby
    localparam lp_lvl_e OFF_AT = (g == 0) ? LV_SRG : LV_STBY;
    assign en_o[g] = waking || (lvl_i < OFF_AT);
  end
endmodule

// File: rtl/lp_idle_ctrl.sv
module lp_idle_ctrl
  import lp_pkg::*;
#(
  parameter int THR_W    = 16,
  parameter int SCALE_SH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       dram_type_i,
  input  logic             bus_req_i,
  output logic             bus_rdy_o,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [THR_W-1:0] reg_wdata_i,
  output logic             cmd_vld_o,
  output logic [2:0]       cmd_op_o,
  input  logic             cmd_ack_i,
  output logic [3:0]       clk_en_o,
  output logic [2:0]       lp_state_o
);
  localparam int CNT_W = THR_W + SCALE_SH;

  logic [1:0]         dtype_q;
  logic               typed_q;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_LVL-1:0] expired;
  lp_lvl_e            lvl;
  lp_ph_e             ph;
  lp_op_e             op;
  logic               clr, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dtype_q <= '0;
      typed_q <= 1'b0;
    end else if (!typed_q) begin
      dtype_q <= dram_type_i;
      typed_q <= 1'b1;
    end
  end

  assign active = (lvl == LV_ACT) && (ph == PH_RUN);

  lp_thr_regs #(.THR_W(THR_W), .SCALE_SH(SCALE_SH), .ADDR_W(3)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .wr_ok_i   (active),
    .lp4_i     (dtype_q == DT_LP4),
    .cnt_i     (cnt),
    .expired_o (expired)
  );

  lp_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idle_i (!bus_req_i),
    .hold_i (!active),
    .clr_i  (clr),
    .cnt_o  (cnt)
  );

  lp_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_req_i (bus_req_i),
    .expired_i (expired),
    .ack_i     (cmd_ack_i),
    .lvl_o     (lvl),
    .ph_o      (ph),
    .cmd_vld_o (cmd_vld_o),
    .cmd_op_o  (op),
    .clr_o     (clr)
  );

  lp_gate_dec u_gate (
    .lvl_i (lvl),
    .ph_i  (ph),
    .en_o  (clk_en_o)
  );

  assign cmd_op_o   = op;
  assign lp_state_o = lvl;
  assign bus_rdy_o  = active;
endmodule

// File: rtl/lp_idle_ctrl_chk.sv
module lp_idle_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_rdy_o,
  input logic       cmd_vld_o,
  input logic [2:0] cmd_op_o,
  input logic [3:0] clk_en_o,
  input logic [2:0] lp_state_o,
  input logic [1:0] dtype_q
);
  p_rdy_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdy_o |-> lp_state_o == 3'd0);

  p_srpd_lp4_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_state_o == 3'd4 |-> dtype_q == 2'd2);

  p_exit_ungated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && cmd_op_o == 3'd4) |-> clk_en_o == 4'hF);

  p_deeper_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_state_o != $past(lp_state_o) && lp_state_o != 3'd0)
      |-> lp_state_o > $past(lp_state_o));

  p_stby_gates_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o[3:1] != 3'b111) |-> lp_state_o == 3'd5);

  p_mc_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o[0] |-> lp_state_o >= 3'd3);

  p_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |=> !cmd_vld_o);
endmodule

bind lp_idle_ctrl lp_idle_ctrl_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_rdy_o  (bus_rdy_o),
  .cmd_vld_o  (cmd_vld_o),
  .cmd_op_o   (cmd_op_o),
  .clk_en_o   (clk_en_o),
  .lp_state_o (lp_state_o),
  .dtype_q    (dtype_q)
);

// File: tb/lp_idle_ctrl_tb_top.sv
`timescale 1ns/1ps
module lp_idle_ctrl_tb_top;
  localparam int THR_W = 8;
  localparam int SH    = 3;
  localparam int SCALE = 1 << SH;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       dram_type = 2'd0;
  logic             bus_req = 1'b1;
  logic             bus_rdy;
  logic             we = 1'b0;
  logic [2:0]       addr = '0;
  logic [THR_W-1:0] wdata = '0;
  logic             cmd_vld;
  logic [2:0]       cmd_op;
  logic             cmd_ack = 1'b0;
  logic [3:0]       clk_en;
  logic [2:0]       lp_state;

  int checks = 0, failures = 0, cycles = 0, ack_lat = 2, ack_cd = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  lp_idle_ctrl #(.THR_W(THR_W), .SCALE_SH(SH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dram_type_i(dram_type),
    .bus_req_i(bus_req), .bus_rdy_o(bus_rdy),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .cmd_vld_o(cmd_vld), .cmd_op_o(cmd_op), .cmd_ack_i(cmd_ack),
    .clk_en_o(clk_en), .lp_state_o(lp_state)
  );

  // ---------------- reference model ----------------
  int m_lvl, m_ph, m_pend, m_cnt, m_op, m_type;
  bit m_vld, m_typed;
  int m_thr[5];

  function automatic int mode_of(int l);
    if (l == 1) return 1;
    if (l == 4) return 3;
    if (l == 2 || l == 3 || l == 5) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = 0; m_ph = 0; m_pend = 0; m_cnt = 0; m_op = 0; m_vld = 0;
      m_type = 0; m_typed = 0;
      for (int i = 0; i < 5; i++) m_thr[i] = 0;
    end else begin
      int t, lim;
      bit wr_ok, req, ack;
      req = bus_req; ack = cmd_ack;
      wr_ok = (m_lvl == 0 && m_ph == 0);
      t = 0;
      for (int k = 1; k <= 5; k++) begin
        lim = (k >= 2 && k <= 4) ? m_thr[k-1] * SCALE : m_thr[k-1];
        if (m_thr[k-1] != 0 && m_cnt >= lim && (k != 4 || m_type == 2)) t = k;
      end
      // counter
      if (m_ph == 3 && ack) m_cnt = 0;
      else if (!req) begin if (m_cnt < (1 << (THR_W + SH)) - 1) m_cnt++; end
      else if (wr_ok) m_cnt = 0;
      // sequence
      m_vld = 0;
      case (m_ph)
        0: if (m_lvl != 0 && req) m_ph = 2;
           else if (!req && t > m_lvl) begin
             if (mode_of(t) != mode_of(m_lvl)) begin
               m_vld = 1; m_op = mode_of(t); m_pend = t; m_ph = 1;
             end else m_lvl = t;
           end
        1: if (ack) begin m_lvl = m_pend; m_ph = 0; end
        2: begin m_vld = 1; m_op = 4; m_ph = 3; end
        default: if (ack) begin m_lvl = 0; m_ph = 0; end
      endcase
      if (we && wr_ok && addr < 5) m_thr[addr] = int'(wdata);
      if (!m_typed) begin m_type = int'(dram_type); m_typed = 1; end
    end
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int en;
      en = (m_ph >= 2) ? 15 : ((m_lvl < 3 ? 1 : 0) | (m_lvl < 5 ? 14 : 0));
      check_eq(cur_req, "lp_state", int'(lp_state), m_lvl);
      check_eq(cur_req, "bus_rdy", int'(bus_rdy), (m_lvl == 0 && m_ph == 0) ? 1 : 0);
      check_eq(cur_req, "clk_en", int'(clk_en), en);
      check_eq(cur_req, "cmd_vld", int'(cmd_vld), int'(m_vld));
      if (m_vld) check_eq(cur_req, "cmd_op", int'(cmd_op), m_op);
    end
  end

  // acknowledge responder
  always @(negedge clk) begin
    cmd_ack = 1'b0;
    if (ack_cd > 0) begin
      ack_cd--;
      if (ack_cd == 0) cmd_ack = 1'b1;
    end
    if (rst_n && cmd_vld) ack_cd = ack_lat;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset(logic [1:0] ty);
    @(negedge clk);
    rst_n = 1'b0; dram_type = ty; bus_req = 1'b1; ack_cd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wdata = THR_W'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic go_idle();
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wake();
    bus_req = 1'b1;
    for (int i = 0; i < 60 && !bus_rdy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(string req, int exp_n, int exp_op);
    int n;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (cmd_vld) break;
    end
    check_eq(req, "entry_cycles", n, exp_n);
    check_eq(req, "entry_op", int'(cmd_op), exp_op);
  endtask

  initial begin
    // ---- DDR3 ----
    do_reset(2'd0);
    cmp_on = 1;
    cur_req = "R1";
    check_eq("R1", "state", int'(lp_state), 0);
    check_eq("R1", "clk_en", int'(clk_en), 15);
    check_eq("R1", "rdy", int'(bus_rdy), 1);
    check_eq("R1", "vld", int'(cmd_vld), 0);
    cur_req = "R7";
    go_idle();
    repeat (40) @(negedge clk);
    check_eq("R7", "no_entry_zero_thr", int'(lp_state), 0);
    bus_req = 1'b1;

    cur_req = "R2";
    wr(0, 5);
    go_idle();
    measure("R2", 6, 1);
    repeat (5) @(negedge clk);
    check_eq("R2", "state_pd", int'(lp_state), 1);
    cur_req = "R10";
    wake();
    go_idle();
    measure("R10", 6, 1);
    repeat (5) @(negedge clk);
    wake();

    cur_req = "R3";
    wr(0, 0); wr(1, 2); wr(2, 3); wr(3, 4);
    go_idle();
    measure("R3", 2 * SCALE + 1, 2);
    cur_req = "R4";
    repeat (15) @(negedge clk);
    check_eq("R4", "state_srg", int'(lp_state), 3);
    check_eq("R4", "mc_gated", int'(clk_en), 14);
    cur_req = "R5";
    repeat (20) @(negedge clk);
    check_eq("R5", "no_srpd_ddr3", int'(lp_state), 3);

    cur_req = "R11";
    wr(0, 1);
    wr(1, 0);
    wake();
    wr(1, 0); wr(2, 0); wr(3, 0);
    wr(6, 1); wr(7, 1);
    go_idle();
    repeat (30) @(negedge clk);
    check_eq("R11", "ignored_writes", int'(lp_state), 0);
    bus_req = 1'b1;

    cur_req = "R6";
    wr(1, 2); wr(4, 30);
    go_idle();
    measure("R6", 2 * SCALE + 1, 2);
    repeat (20) @(negedge clk);
    check_eq("R6", "state_stby", int'(lp_state), 5);
    check_eq("R6", "all_gated", int'(clk_en), 0);
    cur_req = "R9";
    bus_req = 1'b1;
    @(negedge clk);
    check_eq("R9", "ungate_first", int'(clk_en), 15);
    check_eq("R9", "no_strobe_yet", int'(cmd_vld), 0);
    @(negedge clk);
    check_eq("R9", "exit_strobe", int'(cmd_vld), 1);
    check_eq("R9", "exit_op", int'(cmd_op), 4);
    check_eq("R9", "held_off", int'(bus_rdy), 0);
    wake();
    check_eq("R9", "rdy_after_exit", int'(bus_rdy), 1);

    cur_req = "R8";
    wr(1, 0); wr(0, 3); wr(4, 3);
    go_idle();
    measure("R8", 4, 2);
    repeat (4) @(negedge clk);
    check_eq("R8", "deepest_stby", int'(lp_state), 5);
    check_eq("R6", "gated_after_sr", int'(clk_en), 0);
    wake();

    // ---- LPDDR4 ----
    cmp_on = 0;
    do_reset(2'd2);
    cmp_on = 1;
    cur_req = "R1";
    check_eq("R1", "state_lp4", int'(lp_state), 0);
    go_idle();
    repeat (30) @(negedge clk);
    check_eq("R7", "thr_reset_zero", int'(lp_state), 0);
    bus_req = 1'b1;
    cur_req = "R5";
    ack_lat = 3;
    wr(1, 1); wr(3, 2);
    go_idle();
    measure("R5", SCALE + 1, 2);
    measure("R5", SCALE, 3);
    cur_req = "R12";
    wake();
    check_eq("R12", "wake_during_entry", int'(lp_state), 0);
    check_eq("R12", "rdy", int'(bus_rdy), 1);
    repeat (5) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule